// File: doc/BRIEF.md
# Register Renaming Map Table

This block sits in the rename stage of an out-of-order core. Each instruction presented to it names two source registers and, optionally, one destination register, all out of a set of architectural registers. The block translates each source through a table that holds, for every architectural register, the hidden rename register that last became its owner. It then takes a fresh rename register from a pool and binds the destination to it. Software cannot address the rename registers. Because every write gets a new hidden register, reusing an architectural name no longer forces write-after-read or write-after-write ordering. Later readers follow the table to the newest owner.

The pool is tracked as a free bit per rename register. The commit side returns registers through a release strobe. The block stalls while no rename register is free. Results leave on registered outputs one cycle after an instruction is accepted. Only a reset restores the table to its all-architectural state.

Top module: `rename_map_table`

## Requirements
- R1: After reset every rename register is free, every architectural register reads back as unmapped, `out_valid` is 0 and `ren_stall` is 0.
- R2: A source whose architectural register has never been bound since reset reports renamed flag 0 with tag 0. Architectural register 0 always reports renamed flag 0 with tag 0.
- R3: An accepted instruction with `ren_dst_wr`=1 and a nonzero destination receives the lowest-numbered free rename register. That register is reported on `out_dst_tag` with `out_dst_alloc`=1, and it stops being free.
- R4: A source reads the rename register most recently bound to its architectural register, with renamed flag 1. When the same register is written twice, a reader after the second write sees the second binding.
- R5: When a source and the destination of one instruction name the same register, the source is translated with the binding in force before that instruction's own destination is bound.
- R6: A destination of register 0, or an instruction with `ren_dst_wr`=0, allocates nothing. It reports `out_dst_alloc`=0 with tag 0 and leaves the free pool unchanged.
- R7: While no rename register is free, `ren_stall` is 1 and a presented instruction is dropped. No output is produced for it and the table is unchanged.
- R8: A `rel_valid` strobe marks `rel_tag` free from the next cycle onward. An allocation in the same cycle as the release still sees that register as busy.
- R9: Each accepted instruction yields exactly one `out_valid` pulse on the cycle after acceptance, and results come out in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | An instruction is presented for renaming |
| ren_src1 | input | 5 | First source architectural register |
| ren_src2 | input | 5 | Second source architectural register |
| ren_dst | input | 5 | Destination architectural register |
| ren_dst_wr | input | 1 | Instruction writes its destination |
| ren_stall | output | 1 | No free rename register; presented instruction is dropped |
| rel_valid | input | 1 | Commit returns a rename register |
| rel_tag | input | 5 | Rename register being returned |
| out_valid | output | 1 | Registered results for the instruction accepted last cycle |
| out_src1_tag | output | 5 | Rename register for source 1 (0 when unmapped) |
| out_src1_renamed | output | 1 | Source 1 is held in a rename register |
| out_src2_tag | output | 5 | Rename register for source 2 (0 when unmapped) |
| out_src2_renamed | output | 1 | Source 2 is held in a rename register |
| out_dst_tag | output | 5 | Rename register allocated to the destination |
| out_dst_alloc | output | 1 | A destination rename register was allocated |

## Verification
The bench uses the default parameters: 32 architectural registers and 20 rename registers. With only 20 registers in the pool, about twenty writing instructions drain it. That brings the empty-pool stall and a release that lands on a stalled cycle within reach. It also covers refilling the pool in lowest-index order and the wrap of destination names across all 31 writable registers. The small architectural file makes repeated writes to one register easy to provoke, so same-instruction source/destination overlap gets exercised against a reference table kept in the bench.

// File: rtl/rmt_pkg.sv
package rmt_pkg;
  localparam int unsigned ARCH_REGS_DEF = 32;
  localparam int unsigned PHYS_REGS_DEF = 20;
endpackage

// File: rtl/rmt_free_list.sv
module rmt_free_list #(
  parameter int unsigned N  = rmt_pkg::PHYS_REGS_DEF,
  parameter int unsigned TW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc,
  input  logic          rel_v,
  input  logic [TW-1:0] rel_tag,
  output logic [N-1:0]  free_vec,
  output logic          empty,
  output logic [TW-1:0] grant_tag
);
  logic [N-1:0] free_nxt;

  always_comb begin
    grant_tag = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) grant_tag = TW'(i);
    end
  end

  assign empty = (free_vec == '0);

  always_comb begin
    free_nxt = free_vec;
    if (alloc) free_nxt[grant_tag] = 1'b0;
    if (rel_v) free_nxt[rel_tag] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) free_vec <= '1;
    else     free_vec <= free_nxt;
  end

  // R3: an allocation is only ever requested while a register is free
  a_r3_alloc_not_empty: assert property (@(posedge clk) disable iff (rst)
    alloc |-> !empty);

  // R8: a returned register is in range and currently busy
  a_r8_release_busy: assert property (@(posedge clk) disable iff (rst)
    rel_v |-> (rel_tag < TW'(N)) && !free_vec[rel_tag]);

  // R3: an allocated register is busy on the following cycle
  a_r3_grant_taken: assert property (@(posedge clk) disable iff (rst)
    (alloc && !(rel_v && rel_tag == grant_tag)) |=> !free_vec[$past(grant_tag)]);
endmodule

// File: rtl/rmt_map.sv
module rmt_map #(
  parameter int unsigned AR = rmt_pkg::ARCH_REGS_DEF,
  parameter int unsigned PR = rmt_pkg::PHYS_REGS_DEF,
  parameter int unsigned AW = $clog2(AR),
  parameter int unsigned TW = (PR > 1) ? $clog2(PR) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [TW-1:0] wtag,
  input  logic [AW-1:0] ridx_a,
  output logic [TW-1:0] rtag_a,
  output logic          rren_a,
  input  logic [AW-1:0] ridx_b,
  output logic [TW-1:0] rtag_b,
  output logic          rren_b
);
  logic [TW-1:0] tag_mem [AR];
  logic [AR-1:0] bound;

  always_ff @(posedge clk) begin
    if (we) tag_mem[widx] <= wtag;
  end

  always_ff @(posedge clk) begin
    if (rst)     bound <= '0;
    else if (we) bound[widx] <= 1'b1;
  end

  assign rren_a = bound[ridx_a];
  assign rren_b = bound[ridx_b];
  assign rtag_a = rren_a ? tag_mem[ridx_a] : '0;
  assign rtag_b = rren_b ? tag_mem[ridx_b] : '0;

  // R6: register 0 is never bound to a rename register
  a_r6_no_write_zero: assert property (@(posedge clk) disable iff (rst)
    we |-> widx != '0);

  // R2: register 0 never reads back as renamed
  a_r2_zero_unmapped: assert property (@(posedge clk) disable iff (rst)
    (ridx_a == '0) |-> !rren_a);
endmodule

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int unsigned ARCH_REGS = rmt_pkg::ARCH_REGS_DEF,
  parameter int unsigned PHYS_REGS = rmt_pkg::PHYS_REGS_DEF,
  localparam int unsigned AW = $clog2(ARCH_REGS),
  localparam int unsigned TW = (PHYS_REGS > 1) ? $clog2(PHYS_REGS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ren_valid,
  input  logic [AW-1:0] ren_src1,
  input  logic [AW-1:0] ren_src2,
  input  logic [AW-1:0] ren_dst,
  input  logic          ren_dst_wr,
  output logic          ren_stall,
  input  logic          rel_valid,
  input  logic [TW-1:0] rel_tag,
  output logic          out_valid,
  output logic [TW-1:0] out_src1_tag,
  output logic          out_src1_renamed,
  output logic [TW-1:0] out_src2_tag,
  output logic          out_src2_renamed,
  output logic [TW-1:0] out_dst_tag,
  output logic          out_dst_alloc
);
  logic                 accept, need_alloc, pool_empty;
  logic [TW-1:0]        grant;
  logic [PHYS_REGS-1:0] free_vec;
  logic [TW-1:0]        s1_tag, s2_tag;
  logic                 s1_ren, s2_ren;

  assign ren_stall  = pool_empty;
  assign accept     = ren_valid && !pool_empty;
  assign need_alloc = accept && ren_dst_wr && (ren_dst != '0);

  rmt_free_list #(.N(PHYS_REGS), .TW(TW)) u_free (
    .clk(clk), .rst(rst), .alloc(need_alloc),
    .rel_v(rel_valid), .rel_tag(rel_tag),
    .free_vec(free_vec), .empty(pool_empty), .grant_tag(grant)
  );

  rmt_map #(.AR(ARCH_REGS), .PR(PHYS_REGS), .AW(AW), .TW(TW)) u_map (
    .clk(clk), .rst(rst),
    .we(need_alloc), .widx(ren_dst), .wtag(grant),
    .ridx_a(ren_src1), .rtag_a(s1_tag), .rren_a(s1_ren),
    .ridx_b(ren_src2), .rtag_b(s2_tag), .rren_b(s2_ren)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid        <= 1'b0;
      out_src1_tag     <= '0;
      out_src1_renamed <= 1'b0;
      out_src2_tag     <= '0;
      out_src2_renamed <= 1'b0;
      out_dst_tag      <= '0;
      out_dst_alloc    <= 1'b0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_src1_tag     <= s1_tag;
        out_src1_renamed <= s1_ren;
        out_src2_tag     <= s2_tag;
        out_src2_renamed <= s2_ren;
        out_dst_tag      <= need_alloc ? grant : '0;
        out_dst_alloc    <= need_alloc;
      end
    end
  end

  // R7: a stalled instruction produces no result
  a_r7_stall_drops: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && ren_stall) |=> !out_valid);

  // R3: a freshly reported destination register is not in the free pool
  a_r3_dst_busy: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_dst_alloc) |-> !free_vec[out_dst_tag]);

  // R2: an unmapped operand reports tag 0
  a_r2_unmapped_tag_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_src1_renamed) |-> out_src1_tag == '0);
endmodule

// File: tb/rename_map_table_test.sv
module rename_map_table_test;
  localparam int AR = 32;
  localparam int PR = 20;

  logic       clk = 1'b0;
  logic       rst;
  logic       ren_valid, ren_dst_wr, rel_valid;
  logic [4:0] ren_src1, ren_src2, ren_dst, rel_tag;
  logic       ren_stall, out_valid;
  logic [4:0] out_src1_tag, out_src2_tag, out_dst_tag;
  logic       out_src1_renamed, out_src2_renamed, out_dst_alloc;

  rename_map_table uut (
    .clk(clk), .rst(rst), .ren_valid(ren_valid),
    .ren_src1(ren_src1), .ren_src2(ren_src2), .ren_dst(ren_dst),
    .ren_dst_wr(ren_dst_wr), .ren_stall(ren_stall),
    .rel_valid(rel_valid), .rel_tag(rel_tag),
    .out_valid(out_valid),
    .out_src1_tag(out_src1_tag), .out_src1_renamed(out_src1_renamed),
    .out_src2_tag(out_src2_tag), .out_src2_renamed(out_src2_renamed),
    .out_dst_tag(out_dst_tag), .out_dst_alloc(out_dst_alloc)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit m_ren  [AR];
  int m_tag  [AR];
  bit m_free [PR];

  // expected item: {s1_ren, s1_tag, s2_ren, s2_tag, dst_alloc, dst_tag}
  logic [17:0] exp_q [$];
  string       req_q [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit pool_empty();
    for (int i = 0; i < PR; i++) if (m_free[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic step(input bit iv, input int s1, input int s2, input int d,
                      input bit wr, input bit rv, input int rt, input string req);
    bit st;
    int g;
    logic [17:0] e;
    @(negedge clk);
    st = pool_empty();
    check(ren_stall == st, {req, "/R7 stall"}, ren_stall, st);
    if (iv && !st) begin
      e[17]    = m_ren[s1];
      e[16:13] = 4'(m_ren[s1] ? m_tag[s1] : 0);
      e[12]    = m_ren[s2];
      e[11:8]  = 4'(m_ren[s2] ? m_tag[s2] : 0);
      e[7:5]   = 3'b0;
      e[4:0]   = 5'd0;
      if (wr && d != 0) begin
        g = -1;
        for (int i = PR - 1; i >= 0; i--) if (m_free[i]) g = i;
        e[5] = 1'b1;
        e[4:0] = 5'(g);
        m_free[g] = 1'b0;
        m_ren[d] = 1'b1;
        m_tag[d] = g;
      end
      exp_q.push_back(e);
      req_q.push_back(req);
    end
    if (rv) m_free[rt] = 1'b1;
    ren_valid  = iv;
    ren_src1   = 5'(s1);
    ren_src2   = 5'(s2);
    ren_dst    = 5'(d);
    ren_dst_wr = wr;
    rel_valid  = rv;
    rel_tag    = 5'(rt);
  endtask

  // monitor: compares registered results against the scoreboard
  initial begin
    logic [17:0] e, a;
    string r;
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        a = {out_src1_renamed, out_src1_tag[3:0], out_src2_renamed, out_src2_tag[3:0],
             2'b00, out_dst_alloc, out_dst_tag};
        if (out_src1_tag[4] || out_src2_tag[4]) a[7] = 1'b1;
        if (exp_q.size() == 0) begin
          check(0, "R9 unexpected out_valid (R7 dropped)", 1, 0);
        end else begin
          e = exp_q.pop_front();
          r = req_q.pop_front();
          check(a == e, r, int'(a), int'(e));
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    check(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < AR; i++) begin m_ren[i] = 0; m_tag[i] = 0; end
    for (int i = 0; i < PR; i++) m_free[i] = 1;
    rst = 1; ren_valid = 0; ren_src1 = 0; ren_src2 = 0; ren_dst = 0;
    ren_dst_wr = 0; rel_valid = 0; rel_tag = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    check(ren_stall == 0, "R1 stall after reset", ren_stall, 0);

    step(1, 5, 6, 0, 0, 0, 0, "R1/R2 unmapped lookup");
    step(1, 0, 31, 9, 0, 0, 0, "R6 no write flag");
    step(1, 5, 5, 5, 1, 0, 0, "R5 src equals dst, R3 first alloc");
    step(1, 5, 0, 7, 1, 0, 0, "R4 reader sees binding, R2 reg0");
    step(1, 7, 3, 5, 1, 0, 0, "R3 second alloc");
    step(1, 5, 7, 0, 1, 0, 0, "R4 WAW newest binding, R6 dst zero");
    step(1, 5, 5, 5, 1, 0, 0, "R5 overlap after rebind");
    step(0, 0, 0, 0, 0, 0, 0, "R9 idle");
    step(1, 1, 2, 3, 1, 0, 0, "R6 pool unchanged by dst zero");
    // drain the pool
    for (int k = 0; k < 20; k++)
      step(1, (k % 31) + 1, 5, ((k * 7) % 31) + 1, 1, 0, 0, "R3 drain");
    step(1, 5, 7, 9, 1, 0, 0, "R7 stalled drop");
    step(1, 9, 9, 9, 1, 1, 7, "R7 stalled with R8 release");
    step(1, 9, 5, 9, 1, 1, 3, "R8 released tag reused");
    step(1, 9, 5, 11, 1, 0, 0, "R8 release then alloc");
    step(1, 11, 9, 12, 1, 1, 0, "R8 release zero");
    step(1, 12, 11, 0, 0, 1, 19, "R8 release top");
    step(1, 12, 11, 13, 1, 0, 0, "R3 lowest free after release");
    step(1, 13, 12, 14, 1, 0, 0, "R3 highest free");
    step(1, 14, 13, 15, 1, 0, 0, "R7 empty again");
    step(0, 0, 0, 0, 0, 0, 0, "R9 flush");
    step(0, 0, 0, 0, 0, 0, 0, "R9 flush");
    check(exp_q.size() == 0, "R9 all results seen", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule